// File: doc/BRIEF.md
# Receive Packet DWORD Read Formatter

This block turns a receive byte stream into 32-bit words for a host read port. Each packet's bytes enter a local byte FIFO with an end-of-packet marker. A packer places them into DWORDs in little-endian order. Before the first data byte it inserts a programmable number of zero bytes, from 0 to 31. After the last data byte it appends zero bytes and then whole zero DWORDs, so that the packet's total read length ends on a 4-, 16- or 32-byte boundary. The host drops the leading and trailing filler.

A DWORD countdown runs beside the read port. Software loads it with the number of DWORDs it expects to read. Each DWORD the host reads lowers the count by one, and a sticky interrupt is raised when the count reaches zero. A discard strobe drops everything pending: the byte FIFO, the partly built word and the word waiting at the read port. The same strobe sends a clear pulse to the companion status FIFO.

Configuration is guarded so that a packet in flight is never reformatted. The alignment and the offset are sampled when a packet starts. The byte part of the offset is accepted only while the block holds no data at all.

Top module: `rxpkt_dword_fmt`

## Requirements
- R1: Packet bytes are packed little-endian: the first byte of the output stream occupies bits [7:0] of the first DWORD, the next byte bits [15:8], and so on.
- R2: With an offset of N bytes (0..31) in effect, the first N bytes of the output stream are zero and the first data byte is byte N of the stream.
- R3: After the last data byte, zero bytes fill the rest of its DWORD, and zero DWORDs are then appended until the packet's DWORD total is a multiple of 1, 4 or 8 for alignment codes 00, 01 and 10 (4, 16 and 32 bytes). No further DWORD follows.
- R4: A configuration write of alignment code 11 behaves exactly like code 00 (4-byte end alignment).
- R5: The alignment is sampled when a packet starts. A change written while a packet is partly processed leaves that packet's padding unchanged and applies to the next packet.
- R6: A configuration write always updates the DWORD part of the offset, bits [4:2]. It updates the byte part, bits [1:0], only when the byte FIFO is empty, the packer is idle and no word waits at the read port. The offset in effect is sampled at each packet start.
- R7: Each DWORD read while the count is nonzero lowers the count by one. The read that takes the count from 1 to 0 sets `rx_irq`. A read with the count at zero leaves it at zero.
- R8: A count load replaces the current value at once, even before zero is reached, and counting continues from the loaded value. A load wins over a read in the same cycle.
- R9: `rx_irq` stays high until `irq_clr` is pulsed. It rises again only after a new nonzero count has been counted down to zero. A load of 0 does not raise it.
- R10: A `discard` pulse empties the byte FIFO, drops the partly built word and the pending read word, and returns the packer to idle. The next cycle it drives a one-cycle `stat_fifo_clr` pulse. The next packet is formatted from a clean start.
- R11: After reset, `rd_valid`, `rx_irq` and `stat_fifo_clr` are 0, `dma_cnt` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte valid |
| in_byte | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Byte FIFO can accept a byte |
| rd_en | input | 1 | Host takes the word at the read port |
| rd_valid | output | 1 | A DWORD is available |
| rd_data | output | 32 | DWORD at the read port, little-endian |
| cfg_wr | input | 1 | Write the alignment and offset fields |
| cfg_align | input | 2 | End alignment code: 00 4B, 01 16B, 10 32B, 11 as 00 |
| cfg_offset | input | 5 | Start offset in bytes |
| cnt_wr | input | 1 | Load the DWORD countdown |
| cnt_val | input | 12 | Value to load |
| irq_clr | input | 1 | Clear the receive-data interrupt |
| discard | input | 1 | Drop all pending receive data |
| dma_cnt | output | 12 | Current countdown value |
| rx_irq | output | 1 | Receive-data interrupt |
| stat_fifo_clr | output | 1 | Clear pulse for the status FIFO |

## Verification
The bench uses the default parameters: a 64-entry byte FIFO, a 5-bit offset and a 12-bit counter. With a 64-byte FIFO, a 33-byte packet behind a 31-byte offset or a 32-byte alignment can be queued in full before any read. That brings multi-DWORD padding and the largest offset within reach. The 12-bit counter lets short countdowns, reloads in mid-count and reads at a count of zero be shown within a few packets.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

   typedef enum logic [1:0] {
      PK_IDLE = 2'd0,
      PK_OFF  = 2'd1,
      PK_DATA = 2'd2,
      PK_PAD  = 2'd3
   } pk_state_t;

   localparam logic [1:0] ALN_4B   = 2'b00;
   localparam logic [1:0] ALN_16B  = 2'b01;
   localparam logic [1:0] ALN_32B  = 2'b10;
   localparam logic [1:0] ALN_RSVD = 2'b11;

   // Mask on the per-packet DWORD counter: zero when on the boundary.
   function automatic logic [2:0] align_mask(input logic [1:0] code);
      case (code)
         ALN_16B: align_mask = 3'b011;
         ALN_32B: align_mask = 3'b111;
         default: align_mask = 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/rxfmt_byte_fifo.sv
module rxfmt_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int DW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          full,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxfmt_byte_fifo: DEPTH must be a power of two >= 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wp_q, rp_q;
   logic          do_wr, do_rd;

   assign empty   = (wp_q == rp_q);
   assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign do_wr   = wr_en && !full && !clr;
   assign do_rd   = rd_en && !empty && !clr;
   assign rd_data = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + 1'b1;
         if (do_rd) rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q[AW-1:0]] <= wr_data;
   end

   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
   a_r10_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en && !clr) |=> full && $stable(wp_q));

endmodule

// File: rtl/rxfmt_dword_packer.sv
module rxfmt_dword_packer
   import rxfmt_pkg::*;
#(
   parameter int OFF_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [OFF_W-1:0] off_cfg,
   input  logic [1:0]       align_cfg,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_byte,
   input  logic             fifo_last,
   output logic             fifo_pop,
   output logic             out_valid,
   output logic [31:0]      out_data,
   input  logic             out_take,
   output logic             idle
);
   localparam int LANES = 4;

   pk_state_t        st_q, st_d;
   logic [OFF_W-1:0] offc_q, offc_d;
   logic [1:0]       lane_q;
   logic [2:0]       dwc_q;
   logic [2:0]       mask_q;
   logic             emit, slot_ok, start;
   logic [7:0]       bval;
   logic [23:0]      asm_w;

   assign slot_ok = (lane_q != 2'd3) || !out_valid || out_take;
   assign idle    = (st_q == PK_IDLE);

   always_comb begin
      st_d     = st_q;
      offc_d   = offc_q;
      emit     = 1'b0;
      fifo_pop = 1'b0;
      bval     = 8'h00;
      start    = 1'b0;
      case (st_q)
         PK_IDLE: begin
            if (!fifo_empty) begin
               start  = 1'b1;
               offc_d = off_cfg;
               st_d   = (off_cfg == '0) ? PK_DATA : PK_OFF;
            end
         end
         PK_OFF: begin
            if (slot_ok) begin
               emit   = 1'b1;
               offc_d = offc_q - 1'b1;
               if (offc_q == OFF_W'(1)) st_d = PK_DATA;
            end
         end
         PK_DATA: begin
            if (!fifo_empty && slot_ok) begin
               emit     = 1'b1;
               fifo_pop = 1'b1;
               bval     = fifo_byte;
               if (fifo_last) st_d = PK_PAD;
            end
         end
         PK_PAD: begin
            if (lane_q == 2'd0 && (dwc_q & mask_q) == 3'd0) st_d = PK_IDLE;
            else if (slot_ok) emit = 1'b1;
         end
         default: st_d = PK_IDLE;
      endcase
   end

   // Per-lane holding bytes for lanes 0..2; lane 3 completes the word.
   for (genvar l = 0; l < LANES - 1; l++) begin : g_lane
      logic [7:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              b_q <= '0;
         else if (flush)                          b_q <= '0;
         else if (emit && lane_q == 2'(l))        b_q <= bval;
      end
      assign asm_w[l*8 +: 8] = b_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PK_IDLE;
         offc_q    <= '0;
         lane_q    <= '0;
         dwc_q     <= '0;
         mask_q    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (flush) begin
         st_q      <= PK_IDLE;
         offc_q    <= '0;
         lane_q    <= '0;
         dwc_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         st_q   <= st_d;
         offc_q <= offc_d;
         if (start) begin
            dwc_q  <= '0;
            mask_q <= align_mask(align_cfg);
         end
         if (emit) begin
            lane_q <= lane_q + 1'b1;
            if (lane_q == 2'd3) dwc_q <= dwc_q + 1'b1;
         end
         if (emit && lane_q == 2'd3) begin
            out_valid <= 1'b1;
            out_data  <= {bval, asm_w};
         end else if (out_take) begin
            out_valid <= 1'b0;
         end
      end
   end

   a_r1_word_held: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (out_valid && !out_take) |=> out_valid && $stable(out_data));
   a_r3_pad_ends_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PK_IDLE && $past(st_q) == PK_PAD && !$past(flush))
      |-> lane_q == 2'd0 && (dwc_q & mask_q) == 3'd0);
   a_r5_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PK_IDLE && $past(st_q) != PK_IDLE) |-> $stable(mask_q));

endmodule

// File: rtl/rxfmt_dma_counter.sv
module rxfmt_dma_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   if (CNT_W < 2) begin : g_bad_w
      $error("rxfmt_dma_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         if (load) begin
            cnt <= load_val;
         end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
         if (!load && dec && cnt == CNT_W'(1)) irq <= 1'b1;
         else if (irq_clr)                     irq <= 1'b0;
      end
   end

   a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));
   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   a_r9_irq_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> cnt == '0);

endmodule

// File: rtl/rxpkt_dword_fmt.sv
module rxpkt_dword_fmt
   import rxfmt_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = 12,
   parameter int OFF_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             in_last,
   output logic             in_ready,
   input  logic             rd_en,
   output logic             rd_valid,
   output logic [31:0]      rd_data,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_align,
   input  logic [OFF_W-1:0] cfg_offset,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             irq_clr,
   input  logic             discard,
   output logic [CNT_W-1:0] dma_cnt,
   output logic             rx_irq,
   output logic             stat_fifo_clr
);
   localparam int FW = 9;

   if (OFF_W < 3) begin : g_bad_off
      $error("rxpkt_dword_fmt: OFF_W must be at least 3");
   end

   logic [1:0]       align_q;
   logic [OFF_W-1:0] off_q;
   logic             f_full, f_empty, f_pop, pk_idle, rx_idle, rd_fire;
   logic [FW-1:0]    f_rdata;

   assign in_ready = !f_full;
   assign rd_fire  = rd_en && rd_valid;
   assign rx_idle  = f_empty && pk_idle && !rd_valid;

   rxfmt_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(FW)) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (discard),
      .wr_en   (in_valid),
      .wr_data ({in_last, in_byte}),
      .full    (f_full),
      .rd_en   (f_pop),
      .rd_data (f_rdata),
      .empty   (f_empty)
   );

   rxfmt_dword_packer #(.OFF_W(OFF_W)) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (discard),
      .off_cfg    (off_q),
      .align_cfg  (align_q),
      .fifo_empty (f_empty),
      .fifo_byte  (f_rdata[7:0]),
      .fifo_last  (f_rdata[8]),
      .fifo_pop   (f_pop),
      .out_valid  (rd_valid),
      .out_data   (rd_data),
      .out_take   (rd_en),
      .idle       (pk_idle)
   );

   rxfmt_dma_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_wr),
      .load_val (cnt_val),
      .dec      (rd_fire),
      .irq_clr  (irq_clr),
      .cnt      (dma_cnt),
      .irq      (rx_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         align_q       <= ALN_4B;
         off_q         <= '0;
         stat_fifo_clr <= 1'b0;
      end else begin
         stat_fifo_clr <= discard;
         if (cfg_wr) begin
            align_q           <= (cfg_align == ALN_RSVD) ? ALN_4B : cfg_align;
            off_q[OFF_W-1:2]  <= cfg_offset[OFF_W-1:2];
            if (rx_idle) off_q[1:0] <= cfg_offset[1:0];
         end
      end
   end

   a_r6_byte_part_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !rx_idle) |=> off_q[1:0] == $past(off_q[1:0]));
   a_r4_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> align_q != ALN_RSVD);
   a_r10_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      discard |=> stat_fifo_clr && !rd_valid);

endmodule

// File: tb/test_rxpkt_dword_fmt.sv
module test_rxpkt_dword_fmt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0, rd_en = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        cfg_wr = 1'b0, cnt_wr = 1'b0, irq_clr = 1'b0, discard = 1'b0;
   logic [1:0]  cfg_align = '0;
   logic [4:0]  cfg_offset = '0;
   logic [11:0] cnt_val = '0;
   logic        in_ready, rd_valid, rx_irq, stat_fifo_clr;
   logic [31:0] rd_data;
   logic [11:0] dma_cnt;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   rxpkt_dword_fmt i_rxpkt_dword_fmt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .in_ready(in_ready), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .cfg_wr(cfg_wr), .cfg_align(cfg_align),
      .cfg_offset(cfg_offset), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
      .irq_clr(irq_clr), .discard(discard), .dma_cnt(dma_cnt), .rx_irq(rx_irq),
      .stat_fifo_clr(stat_fifo_clr)
   );

   // {length[7:0], offset[4:0], align code[1:0]}
   localparam int NV = 11;
   localparam logic [14:0] VEC [NV] = '{
      {8'd1,  5'd0,  2'd0}, {8'd4,  5'd0,  2'd0}, {8'd5,  5'd0,  2'd0},
      {8'd3,  5'd1,  2'd0}, {8'd7,  5'd2,  2'd1}, {8'd10, 5'd5,  2'd1},
      {8'd13, 5'd9,  2'd2}, {8'd2,  5'd31, 2'd2}, {8'd9,  5'd3,  2'd3},
      {8'd20, 5'd0,  2'd1}, {8'd33, 5'd6,  2'd2}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input logic last);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_last = last;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic push_range(input int first, input int len, input int total,
                             input logic [7:0] base);
      for (int i = first; i < first + len; i++)
         push(base + 8'(i), (i == total - 1));
   endtask

   task automatic read_word(output logic [31:0] w);
      int guard = 0;
      @(negedge clk);
      while (!rd_valid && guard < 200) begin @(negedge clk); guard++; end
      w = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] al, input logic [4:0] off);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_align = al; cfg_offset = off;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   function automatic logic [7:0] exp_byte(input int k, input int len, input int off,
                                           input logic [7:0] base);
      if (k < off || k >= off + len) return 8'h00;
      return base + 8'(k - off);
   endfunction

   function automatic int exp_words(input int len, input int off, input logic [1:0] al);
      int dw = (off + len + 3) / 4;
      int a = (al == 2'd1) ? 4 : (al == 2'd2) ? 8 : 1;
      return ((dw + a - 1) / a) * a;
   endfunction

   task automatic drain_check(input int len, input int off, input logic [1:0] al,
                              input logic [7:0] base, input string req);
      int nw = exp_words(len, off, al);
      logic [31:0] w, e;
      for (int d = 0; d < nw; d++) begin
         read_word(w);
         for (int b = 0; b < 4; b++) e[b*8 +: 8] = exp_byte(d*4 + b, len, off, base);
         check(w == e, req, $sformatf("word %0d", d), w, e);
      end
      repeat (8) @(negedge clk);
      check(!rd_valid, "R3", "no word beyond padding", rd_valid, 0);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] w;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(!rd_valid && !rx_irq && !stat_fifo_clr, "R11", "outputs idle", rd_valid, 0);
      check(dma_cnt == 0, "R11", "count", dma_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready, "R11", "in_ready", in_ready, 1);

      // R1 R2 R3 R4: table walk
      for (int v = 0; v < NV; v++) begin
         int len = int'(VEC[v][14:7]);
         int off = int'(VEC[v][6:2]);
         logic [1:0] al = VEC[v][1:0];
         logic [7:0] base = 8'(8'h11 * (v + 1));
         string req = (al == 2'd3) ? "R4" : (off != 0) ? "R2" : (al != 0) ? "R3" : "R1";
         set_cfg(al, 5'(off));
         push_range(0, len, len, base);
         drain_check(len, off, al, base, req);
      end

      // R5: alignment change mid-packet applies to next packet
      set_cfg(2'd1, 5'd0);
      push(8'hA0, 1'b0);
      repeat (3) @(negedge clk);
      set_cfg(2'd2, 5'd0);
      push_range(1, 5, 6, 8'hA0);
      drain_check(6, 0, 2'd1, 8'hA0, "R5");
      push_range(0, 6, 6, 8'hB0);
      drain_check(6, 0, 2'd2, 8'hB0, "R5");

      // R6: byte part of offset ignored while busy, DWORD part taken
      set_cfg(2'd0, 5'd0);
      push_range(0, 2, 4, 8'hC0);
      set_cfg(2'd0, 5'd7);
      push_range(2, 2, 4, 8'hC0);
      drain_check(4, 0, 2'd0, 8'hC0, "R6");
      push_range(0, 4, 4, 8'hD0);
      drain_check(4, 4, 2'd0, 8'hD0, "R6");
      set_cfg(2'd0, 5'd0);

      // R7: countdown and interrupt
      @(negedge clk); cnt_wr = 1'b1; cnt_val = 12'd3; @(negedge clk); cnt_wr = 1'b0;
      push_range(0, 16, 16, 8'h40);
      read_word(w); read_word(w);
      check(dma_cnt == 1 && !rx_irq, "R7", "after two reads", dma_cnt, 1);
      read_word(w);
      check(dma_cnt == 0 && rx_irq, "R7", "irq at zero", {dma_cnt, rx_irq}, 1);
      read_word(w);
      check(dma_cnt == 0, "R7", "stays at zero", dma_cnt, 0);
      // R9 sticky, clear
      check(rx_irq, "R9", "sticky", rx_irq, 1);
      @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      check(!rx_irq, "R9", "cleared", rx_irq, 0);
      @(negedge clk); cnt_wr = 1'b1; cnt_val = 12'd0; @(negedge clk); cnt_wr = 1'b0;
      repeat (3) @(negedge clk);
      check(!rx_irq, "R9", "load of zero", rx_irq, 0);

      // R8: reload before zero
      @(negedge clk); cnt_wr = 1'b1; cnt_val = 12'd5; @(negedge clk); cnt_wr = 1'b0;
      push_range(0, 16, 16, 8'h50);
      read_word(w); read_word(w);
      check(dma_cnt == 3, "R8", "before reload", dma_cnt, 3);
      @(negedge clk); cnt_wr = 1'b1; cnt_val = 12'd2; @(negedge clk); cnt_wr = 1'b0;
      read_word(w);
      check(dma_cnt == 1 && !rx_irq, "R8", "after reload read", dma_cnt, 1);
      read_word(w);
      check(dma_cnt == 0 && rx_irq, "R8", "irq from reloaded count", {dma_cnt, rx_irq}, 1);
      @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      repeat (8) @(negedge clk);

      // R10: discard
      push_range(0, 5, 9, 8'h60);
      repeat (4) @(negedge clk);
      check(rd_valid, "R10", "word pending before discard", rd_valid, 1);
      @(negedge clk); discard = 1'b1;
      @(negedge clk); discard = 1'b0;
      check(stat_fifo_clr && !rd_valid, "R10", "status clear pulse", stat_fifo_clr, 1);
      @(negedge clk);
      check(!stat_fifo_clr, "R10", "pulse is one cycle", stat_fifo_clr, 0);
      repeat (6) @(negedge clk);
      check(!rd_valid && in_ready, "R10", "nothing left", rd_valid, 0);
      push_range(0, 7, 7, 8'h70);
      drain_check(7, 0, 2'd0, 8'h70, "R10");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule